// File: doc/BRIEF.md
# Shared Cache Interference Detector

This block works out, for each core, how much extra miss latency other cores impose on it in a shared cache. For every core it holds a shadow tag directory with the same set count and associativity as the shared cache. Each shadow directory sees only that core's own accesses, so it models the cache the core would have if it ran alone. On each access the requesting core's shadow directory is looked up with the same set index as the shared cache, and the result is compared with the shared cache's hit/miss outcome.

A shared miss that the shadow directory would have hit means another core displaced the line, and this is charged as interference. The core's counter then grows by the programmed miss penalty. Losing a line to another core costs nothing on its own; only a later re-reference that misses is charged. The address input is a cache-line address: the low bits select the set and the rest form the tag. The counters are read by whatever resource manager sits above the block.

Top module: `shared_intf_detector`

## Requirements
- R1: After a synchronous active-high reset, every interference counter reads zero, `intf_flag` is low, and the miss penalty equals the `DEF_PEN` parameter.
- R2: Each core has its own shadow directory, and only accesses with that core's `acc_core` value update it. A line fetched by one core never makes another core's shadow lookup hit.
- R3: An access with `shared_hit` = 0 whose line hits in the requesting core's shadow directory adds the current penalty to that core's counter. The new value is visible the cycle after the access. No other counter changes.
- R4: An access with `shared_hit` = 1 never changes any counter, even when the shadow directory also hits.
- R5: An access that misses in the requesting core's shadow directory never changes any counter, whatever `shared_hit` is.
- R6: When another core's accesses push a core's line out of the shared cache, that alone charges nothing. The charge comes only when the owning core re-references the line and the shared cache misses.
- R7: Each shadow set holds `WAYS` tags with least-recently-used replacement. A hit makes the line most recent. A miss replaces the least recent way. No tag is held twice in one set.
- R8: The set is `acc_line[IDX_W-1:0]` and the tag is the remaining upper bits. Lines in different sets never displace each other.
- R9: Every access, including a shared hit, updates the shadow directory. A line first seen on a shared hit counts as a shadow hit on its next access.
- R10: A cycle with `pen_we` = 1 loads `pen_wdata` into the penalty register. Charges from later accesses use the new value.
- R11: Counters are `CNT_W` bits wide (32 by default) and saturate at all ones instead of wrapping.
- R12: The cycle after a charged access, `intf_flag` is high for exactly one cycle and `intf_core` holds the charged core. After an uncharged or idle cycle, `intf_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears counters and shadow state |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_core | input | CORE_W | Requesting core |
| acc_line | input | ADDR_W | Cache-line address of the access |
| shared_hit | input | 1 | Outcome of the shared cache lookup for this access |
| pen_we | input | 1 | Load the miss penalty register |
| pen_wdata | input | PEN_W | New miss penalty value |
| intf_flag | output | 1 | Registered pulse: the previous access was charged |
| intf_core | output | CORE_W | Core charged by the previous access |
| intf_cnt | output | NCORES*CNT_W | Per-core interference latency counters, core c at bits c*CNT_W upward |

## Verification
Directed sequences separate the four outcome cases: a cold miss, an own-capacity LRU eviction, a shared hit and a true cross-core displacement. Only the last may move a counter. Sequences where two cores touch the same lines show that the shadow directories stay private. A shared-hit-then-miss pair shows that shadow updates do not depend on the shared outcome. A penalty change followed by a run of large charges separates correct charging from wrapping. A pseudo-random sweep over a tiny tag space in every set, on both cores and both shared outcomes, is checked against an independent most-recent-first list model of each set.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  // Width of an index that selects one of n items (at least one bit).
  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ifd_shadow_dir.sv
module ifd_shadow_dir import ifd_pkg::*; #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  parameter int IDX_W = bits_for(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic             hit
);
  localparam int AGE_W = bits_for(WAYS);
  localparam int WAY_W = bits_for(WAYS);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [AGE_W-1:0] age_q [SETS][WAYS];

  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way, lru_way, ref_way;
  logic [AGE_W-1:0] ref_age;

  always_comb begin
    hit_way = '0;
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (age_q[idx][w] == AGE_MAX) lru_way = WAY_W'(w);
    end
    hit     = |hit_vec;
    ref_way = hit ? hit_way : lru_way;
    ref_age = age_q[idx][ref_way];
  end

  // Ages form a permutation of 0..WAYS-1 per set; untouched ways drift to the top.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end
    end else if (upd) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == ref_way) age_q[idx][w] <= '0;
        else if (age_q[idx][w] < ref_age) age_q[idx][w] <= age_q[idx][w] + 1'b1;
      end
      if (!hit) begin
        tag_q[idx][ref_way] <= tag;
        vld_q[idx][ref_way] <= 1'b1;
      end
    end
  end

  // R7: one tag never matches two ways of a set
  p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
    upd |-> $onehot0(hit_vec));

  // R7: the referenced way is most recent on the following cycle
  p_ref_becomes_mru_r7: assert property (@(posedge clk) disable iff (rst)
    upd |=> age_q[$past(idx)][$past(ref_way)] == '0);
endmodule

// File: rtl/ifd_sat_ctr.sv
module ifd_sat_ctr #(
  parameter int CNT_W = 32,
  parameter int PEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add,
  input  logic [PEN_W-1:0] amt,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt} + (CNT_W+1)'(amt);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (add) cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
    add |=> cnt >= $past(cnt));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !add |=> $stable(cnt));
endmodule

// File: rtl/shared_intf_detector.sv
module shared_intf_detector import ifd_pkg::*; #(
  parameter int NCORES  = 2,
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 32,
  parameter int PEN_W   = 16,
  parameter int DEF_PEN = 100,
  parameter int CORE_W  = bits_for(NCORES),
  parameter int IDX_W   = bits_for(SETS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_valid,
  input  logic [CORE_W-1:0]       acc_core,
  input  logic [ADDR_W-1:0]       acc_line,
  input  logic                    shared_hit,
  input  logic                    pen_we,
  input  logic [PEN_W-1:0]        pen_wdata,
  output logic                    intf_flag,
  output logic [CORE_W-1:0]       intf_core,
  output logic [NCORES*CNT_W-1:0] intf_cnt
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [PEN_W-1:0]  pen_q;
  logic [NCORES-1:0] shd_hit;
  logic [NCORES-1:0] core_sel;
  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  line_tag;
  logic              charge;

  assign set_idx  = acc_line[IDX_W-1:0];
  assign line_tag = acc_line[ADDR_W-1:IDX_W];
  assign charge   = acc_valid && !shared_hit && shd_hit[acc_core];

  always_ff @(posedge clk) begin
    if (rst)         pen_q <= PEN_W'(DEF_PEN);
    else if (pen_we) pen_q <= pen_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intf_flag <= 1'b0;
      intf_core <= '0;
    end else begin
      intf_flag <= charge;
      if (charge) intf_core <= acc_core;
    end
  end

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic [CNT_W-1:0] cnt_c;

    assign core_sel[c] = acc_valid && (acc_core == CORE_W'(c));

    ifd_shadow_dir #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_dir (
      .clk (clk),
      .rst (rst),
      .upd (core_sel[c]),
      .idx (set_idx),
      .tag (line_tag),
      .hit (shd_hit[c])
    );

    ifd_sat_ctr #(.CNT_W(CNT_W), .PEN_W(PEN_W)) u_ctr (
      .clk (clk),
      .rst (rst),
      .add (charge && core_sel[c]),
      .amt (pen_q),
      .cnt (cnt_c)
    );

    assign intf_cnt[c*CNT_W +: CNT_W] = cnt_c;
  end

  p_shared_hit_free_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && shared_hit) |=> !intf_flag);

  p_idle_no_flag_r12: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !intf_flag);

  p_idle_counters_r3: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> $stable(intf_cnt));

  p_flag_core_r12: assert property (@(posedge clk) disable iff (rst)
    charge |=> (intf_flag && intf_core == $past(acc_core)));
endmodule

// File: tb/sim_shared_intf_detector.sv
module sim_shared_intf_detector;
  localparam int NC = 2, NS = 4, NW = 2, AW = 10, CW = 16, PW = 12, DP = 100;

  logic clk = 0, rst = 1;
  logic acc_valid = 0, shared_hit = 0, pen_we = 0;
  logic [0:0] acc_core = '0;
  logic [AW-1:0] acc_line = '0;
  logic [PW-1:0] pen_wdata = '0;
  logic intf_flag;
  logic [0:0] intf_core;
  logic [NC*CW-1:0] intf_cnt;

  int checks = 0, fails = 0;
  bit done = 0;
  int mru [NC][NS][NW];
  int mv  [NC][NS];
  longint exp_cnt [NC];
  int pen = DP;
  int seed = 12345;

  always #5 clk = ~clk;

  shared_intf_detector #(.NCORES(NC), .SETS(NS), .WAYS(NW), .ADDR_W(AW),
    .CNT_W(CW), .PEN_W(PW), .DEF_PEN(DP)) u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_core(acc_core),
    .acc_line(acc_line), .shared_hit(shared_hit), .pen_we(pen_we),
    .pen_wdata(pen_wdata), .intf_flag(intf_flag), .intf_core(intf_core),
    .intf_cnt(intf_cnt));

  task automatic check(string rq, longint got, longint expv);
    checks++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", rq, got, expv);
    end
  endtask

  // Reference: most-recent-first list per set; returns 1 on hit.
  function automatic bit model_access(int c, int s, int tg);
    int p = -1;
    for (int i = 0; i < mv[c][s]; i++) if (mru[c][s][i] == tg) p = i;
    if (p < 0) begin
      if (mv[c][s] < NW) mv[c][s]++;
      p = mv[c][s] - 1;
    end
    for (int i = p; i > 0; i--) mru[c][s][i] = mru[c][s][i-1];
    mru[c][s][0] = tg;
    return (p >= 0) && (mv[c][s] > 0) && 1'b1;
  endfunction

  function automatic bit model_hit(int c, int s, int tg);
    for (int i = 0; i < mv[c][s]; i++) if (mru[c][s][i] == tg) return 1;
    return 0;
  endfunction

  task automatic acc(int c, int s, int tg, bit sh, string rq);
    bit hit, chg;
    @(negedge clk);
    acc_valid = 1; acc_core = c[0:0]; acc_line = {tg[7:0], s[1:0]}; shared_hit = sh;
    hit = model_hit(c, s, tg);
    void'(model_access(c, s, tg));
    chg = !sh && hit;
    if (chg) begin
      exp_cnt[c] += pen;
      if (exp_cnt[c] > 65535) exp_cnt[c] = 65535;
    end
    @(negedge clk);
    acc_valid = 0;
    check({rq, " flag"}, intf_flag, chg);
    if (chg) check({rq, " core R12"}, intf_core, c);
    for (int k = 0; k < NC; k++) check({rq, " count"}, intf_cnt[k*CW +: CW], exp_cnt[k]);
  endtask

  task automatic set_pen(int v);
    @(negedge clk); pen_we = 1; pen_wdata = v[PW-1:0];
    @(negedge clk); pen_we = 0; pen = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      exp_cnt[c] = 0;
      for (int s = 0; s < NS; s++) mv[c][s] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1 flag", intf_flag, 0);
    for (int k = 0; k < NC; k++) check("R1 count", intf_cnt[k*CW +: CW], 0);

    acc(0, 0, 1, 0, "R5 cold");
    acc(0, 0, 1, 0, "R3 charge");
    check("R1 default penalty", intf_cnt[CW-1:0], DP);
    acc(0, 0, 1, 1, "R4 shared hit");
    acc(1, 0, 1, 0, "R2 private dir");
    acc(1, 0, 2, 0, "R6 polluter");
    acc(1, 0, 3, 0, "R6 polluter");
    acc(0, 0, 1, 0, "R6 re-reference");
    acc(0, 0, 4, 1, "R9 install on hit");
    acc(0, 0, 4, 0, "R9 later miss");
    acc(0, 1, 5, 0, "R7 fill");
    acc(0, 1, 6, 0, "R7 fill");
    acc(0, 1, 5, 1, "R7 touch");
    acc(0, 1, 7, 0, "R7 evict lru");
    acc(0, 1, 6, 0, "R7 evicted miss");
    acc(0, 1, 7, 0, "R7 kept line");
    acc(0, 2, 9, 0, "R8 set a");
    acc(0, 3, 9, 0, "R8 set b");
    acc(0, 2, 9, 0, "R8 no conflict");
    set_pen(7);
    acc(0, 2, 9, 0, "R10 new penalty");
    check("R10 value", intf_cnt[CW-1:0], exp_cnt[0]);
    set_pen(4095);
    acc(1, 3, 11, 1, "R11 prime");
    for (int i = 0; i < 20; i++) acc(1, 3, 11, 0, "R11 saturate");
    check("R11 all ones", intf_cnt[CW +: CW], 65535);
    @(negedge clk);
    check("R12 idle flag", intf_flag, 0);

    set_pen(3);
    for (int i = 0; i < 600; i++) begin
      seed = seed * 1103515245 + 12345;
      acc((seed >>> 16) & 1, (seed >>> 17) & 3, (seed >>> 19) & 3, (seed >>> 21) & 1, "R3 sweep");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule